// File: doc/BRIEF.md
# Decode-Stage Zero-Compare Branch Resolver

This block holds the front end of a five-stage in-order pipeline: the fetch program counter and the fetch/decode pipeline register. It also resolves conditional branches while they sit in decode. Fetch always runs ahead sequentially, so it behaves as if every branch falls through. The instruction in decode is examined for a branch opcode, and the one register operand the branch names is compared against zero. If the branch is taken, the unit steers the next fetch to the branch target and turns the wrongly fetched successor into an all-zero no-op.

A taken branch therefore costs exactly one bubble. A branch that falls through costs nothing beyond its own slot. The squashed successor never leaves the fetch/decode register, so it cannot write any architectural state. The register file, operand forwarding and the later stages sit outside the block. The unit exports the source-register index and receives the value that was read. A decode stall freezes the program counter, the pipeline register and the branch decision together.

Top module: `zbr_front`

## Requirements
- R1: While reset is asserted, the fetch address equals the `RESET_PC` parameter (default 0), and the decode instruction and decode PC are all zero.
- R2: On a cycle with no stall and no redirect, the fetch address advances by 4. The decode register then takes the fetched word and the fetch address it came from.
- R3: An instruction whose bits [31:27] equal 5'b00010 is a branch, and bit 26 selects its condition. With bit 26 at 0 the branch is taken when the register value is zero; with bit 26 at 1 it is taken when the value is non-zero. The register index is bits [25:21] and appears on `rs_idx_o`.
- R4: `target_o` equals the decode PC plus 4 plus the sign-extended bits [15:0] shifted left by two. This holds for negative offsets and wraps modulo 2^XLEN.
- R5: When a branch in decode is taken and decode is not stalled, `redirect_o` is high and the next fetch address equals `target_o`.
- R6: On a taken branch, `flush_o` is high and the decode register becomes all zeros (instruction and PC) on the next cycle. That is one bubble per taken branch and none otherwise.
- R7: While `stall_i` is high, the fetch address and the decode register hold their values, and `redirect_o` and `flush_o` stay low even if a taken branch is in decode.
- R8: Any instruction not matching the branch pattern, including the all-zero bubble, never raises `redirect_o`, whatever register value is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Decode stall: freezes PC, decode register and decision |
| fetch_insn_i | input | 32 | Instruction word read at `pc_o` |
| rs_val_i | input | XLEN | Value of register `rs_idx_o` read in decode |
| pc_o | output | XLEN | Fetch address |
| dec_insn_o | output | 32 | Instruction held in the fetch/decode register |
| dec_pc_o | output | XLEN | PC of the instruction in decode |
| rs_idx_o | output | 5 | Source-register index of the instruction in decode |
| redirect_o | output | 1 | Next-PC select: take `target_o` |
| target_o | output | XLEN | Branch target address |
| flush_o | output | 1 | Clears the fetch/decode register to a no-op |

## Verification
The bench builds the block with its defaults: XLEN of 32 and a reset PC of 0. A 1 KiB program of mixed branches and plain words brings forward and backward branches within reach, including negative offsets that wrap through the stub memory. With half of the register values set to zero, both conditions are exercised in their taken and fall-through forms. Random stalls land on taken branches, so held decisions, and branches directly following a bubble, are covered as well.

// File: rtl/zbr_pkg.sv
package zbr_pkg;
  localparam int INSN_W   = 32;
  localparam int OFS_W    = 16;
  localparam int RIDX_W   = 5;
  localparam int OPC_LSB  = 26;
  localparam int RS_LSB   = 21;
  localparam logic [4:0] BR_OPC_HI = 5'b00010;

  typedef struct packed {
    logic       is_br;
    logic       on_nonzero;
    logic [RIDX_W-1:0] rs;
    logic [OFS_W-1:0]  ofs;
  } br_fields_t;

  function automatic br_fields_t split_insn(input logic [INSN_W-1:0] w);
    br_fields_t f;
    f.is_br      = (w[INSN_W-1:OPC_LSB+1] == BR_OPC_HI);
    f.on_nonzero = w[OPC_LSB];
    f.rs         = w[RS_LSB +: RIDX_W];
    f.ofs        = w[OFS_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/zbr_cond.sv
module zbr_cond
  import zbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_fields_t        fld_i,
  input  logic [XLEN-1:0]   val_i,
  output logic              take_o
);
  logic is_zero;
  always_comb begin
    is_zero = (val_i == '0);
    take_o  = fld_i.is_br & (fld_i.on_nonzero ? ~is_zero : is_zero);
  end
endmodule

// File: rtl/zbr_target.sv
module zbr_target
  import zbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [XLEN-1:0]  tgt_o
);
  localparam int EXT_W = XLEN - OFS_W - 2;
  logic [XLEN-1:0] disp;
  always_comb begin
    disp  = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i, 2'b00};
    tgt_o = pc_i + XLEN'(4) + disp;
  end
endmodule

// File: rtl/zbr_front_regs.sv
module zbr_front_regs
  import zbr_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              redirect_i,
  input  logic [XLEN-1:0]   target_i,
  input  logic [INSN_W-1:0] fetch_insn_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [INSN_W-1:0] dec_insn_o,
  output logic [XLEN-1:0]   dec_pc_o
);
  logic [XLEN-1:0]   pc_q, pc_d, dpc_q, dpc_d;
  logic [INSN_W-1:0] din_q, din_d;

  always_comb begin
    pc_d  = pc_q;
    dpc_d = dpc_q;
    din_d = din_q;
    if (en_i) begin
      if (redirect_i) begin
        pc_d  = target_i;
        din_d = '0;
        dpc_d = '0;
      end else begin
        pc_d  = pc_q + XLEN'(4);
        din_d = fetch_insn_i;
        dpc_d = pc_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      din_q <= '0;
      dpc_q <= '0;
    end else if (en_i) begin
      pc_q  <= pc_d;
      din_q <= din_d;
      dpc_q <= dpc_d;
    end
  end

  assign pc_o       = pc_q;
  assign dec_insn_o = din_q;
  assign dec_pc_o   = dpc_q;
endmodule

// File: rtl/zbr_front.sv
module zbr_front
  import zbr_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic [31:0]       fetch_insn_i,
  input  logic [XLEN-1:0]   rs_val_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [31:0]       dec_insn_o,
  output logic [XLEN-1:0]   dec_pc_o,
  output logic [4:0]        rs_idx_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic              flush_o
);
  br_fields_t fld;
  logic       take_raw;
  logic       redirect;

  assign fld = split_insn(dec_insn_o);

  zbr_cond #(.XLEN(XLEN)) u_cond (
    .fld_i (fld),
    .val_i (rs_val_i),
    .take_o(take_raw)
  );

  zbr_target #(.XLEN(XLEN)) u_tgt (
    .pc_i (dec_pc_o),
    .ofs_i(fld.ofs),
    .tgt_o(target_o)
  );

  assign redirect = take_raw & ~stall_i;

  zbr_front_regs #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (~stall_i),
    .redirect_i  (redirect),
    .target_i    (target_o),
    .fetch_insn_i(fetch_insn_i),
    .pc_o        (pc_o),
    .dec_insn_o  (dec_insn_o),
    .dec_pc_o    (dec_pc_o)
  );

  assign rs_idx_o   = fld.rs;
  assign redirect_o = redirect;
  assign flush_o    = redirect;
endmodule

// File: rtl/zbr_front_chk.sv
module zbr_front_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall_i,
  input logic [XLEN-1:0] pc_o,
  input logic [31:0]     dec_insn_o,
  input logic [XLEN-1:0] dec_pc_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o,
  input logic            flush_o
);
  a_r5_pc_to_target: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> (pc_o == $past(target_o)));

  a_r6_bubble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (dec_insn_o == '0) && (dec_pc_o == '0));

  a_r7_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(pc_o) && $stable(dec_insn_o) && $stable(dec_pc_o));

  a_r7_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !redirect_o && !flush_o);

  a_r2_step_four: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !redirect_o) |=> (pc_o == $past(pc_o) + XLEN'(4)) && (dec_pc_o == $past(pc_o)));

  a_r8_only_branches: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (dec_insn_o[31:27] == 5'b00010));
endmodule

bind zbr_front zbr_front_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall_i   (stall_i),
  .pc_o      (pc_o),
  .dec_insn_o(dec_insn_o),
  .dec_pc_o  (dec_pc_o),
  .redirect_o(redirect_o),
  .target_o  (target_o),
  .flush_o   (flush_o)
);

// File: tb/sim_zbr_front.sv
`timescale 1ns/1ps
module sim_zbr_front;
  localparam int XLEN = 32;
  localparam int RUN  = 4000;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] insn;
    logic [31:0] dpc;
    logic        stalled;
    logic        flushed;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic stall;
  logic [31:0] fetch_insn;
  logic [31:0] rs_val;
  logic [31:0] pc, dec_insn, dec_pc, target;
  logic [4:0]  rs_idx;
  logic        redirect, flush;

  logic [31:0] prog [256];
  logic [31:0] regs [32];

  int n_tests = 0;
  int n_fail  = 0;
  int bubbles_model = 0;
  int bubbles_dut   = 0;
  exp_t sb [$];

  always #2.5 clk = ~clk;

  always_comb begin
    fetch_insn = prog[pc[9:2]];
    rs_val     = regs[rs_idx];
  end

  zbr_front #(.XLEN(XLEN), .RESET_PC('0)) u0 (
    .clk(clk), .rst_n(rst_n), .stall_i(stall),
    .fetch_insn_i(fetch_insn), .rs_val_i(rs_val),
    .pc_o(pc), .dec_insn_o(dec_insn), .dec_pc_o(dec_pc),
    .rs_idx_o(rs_idx), .redirect_o(redirect), .target_o(target),
    .flush_o(flush)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model state
  logic [31:0] m_pc, m_insn, m_dpc;

  function automatic bit m_take(input logic [31:0] w);
    logic [31:0] v;
    v = regs[w[25:21]];
    if (w[31:27] != 5'b00010) return 1'b0;
    return w[26] ? (v != 0) : (v == 0);
  endfunction

  function automatic logic [31:0] m_tgt(input logic [31:0] p, input logic [31:0] w);
    return p + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
  endfunction

  initial begin : wd
    repeat (RUN + 200) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", RUN + 200, RUN);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 32; i++) regs[i] = ($urandom_range(0, 1) == 0) ? 32'd0 : $urandom | 32'd1;
    for (int i = 0; i < 256; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 4) begin
        logic signed [15:0] o;
        o = 16'($signed($urandom_range(0, 20)) - 10);
        prog[i] = {5'b00010, 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), 5'd0, o};
      end else if (k == 4) begin
        prog[i] = 32'd0;
      end else begin
        prog[i] = {6'b001000, 26'($urandom)};
      end
    end
    // special words: a branch with a negative offset wrapping below zero
    prog[3] = {5'b00010, 1'b0, 5'd0, 5'd0, 16'hFFF0};
    regs[0] = 32'd0;

    rst_n = 1'b0;
    stall = 1'b0;
    repeat (3) @(negedge clk);
    check(pc == 32'd0, "R1 pc", pc, 32'd0);
    check(dec_insn == 32'd0, "R1 dec_insn", dec_insn, 32'd0);
    check(dec_pc == 32'd0, "R1 dec_pc", dec_pc, 32'd0);
    rst_n = 1'b1;
    m_pc = 32'd0; m_insn = 32'd0; m_dpc = 32'd0;

    for (int cyc = 0; cyc < RUN; cyc++) begin
      exp_t e;
      bit   tk;
      // monitor: compare state produced by last edge
      if (sb.size() != 0) begin
        e = sb.pop_front();
        if (e.stalled) begin
          check(pc == e.pc, "R7 pc held", pc, e.pc);
          check(dec_insn == e.insn, "R7 insn held", dec_insn, e.insn);
        end else if (e.flushed) begin
          check(pc == e.pc, "R5 pc=target", pc, e.pc);
          check(dec_insn == 32'd0 && dec_pc == 32'd0, "R6 bubble", dec_insn, 32'd0);
        end else begin
          check(pc == e.pc, "R2 pc+4", pc, e.pc);
          check(dec_insn == e.insn, "R2 insn", dec_insn, e.insn);
          check(dec_pc == e.dpc, "R2 dec_pc", dec_pc, e.dpc);
        end
      end
      // driver: new stall value, then compare decisions and push expectation
      stall = ($urandom_range(0, 4) == 0);
      #1;
      tk = m_take(m_insn) && !stall;
      if (m_insn[31:27] == 5'b00010) begin
        check(rs_idx == m_insn[25:21], "R3 rs index", 32'(rs_idx), 32'(m_insn[25:21]));
        check(target == m_tgt(m_dpc, m_insn), "R4 target", target, m_tgt(m_dpc, m_insn));
        if (stall)
          check(redirect == 1'b0 && flush == 1'b0, "R7 no redirect in stall", 32'(redirect), 32'd0);
        else
          check(redirect == tk, "R3 condition", 32'(redirect), 32'(tk));
      end else begin
        check(redirect == 1'b0, "R8 non-branch", 32'(redirect), 32'd0);
      end
      check(flush == redirect, "R6 flush with redirect", 32'(flush), 32'(redirect));
      if (flush) bubbles_dut++;
      if (tk) bubbles_model++;
      e.stalled = stall;
      e.flushed = tk;
      if (stall) begin
        // hold
      end else if (tk) begin
        m_pc = m_tgt(m_dpc, m_insn); m_insn = 32'd0; m_dpc = 32'd0;
      end else begin
        m_insn = prog[m_pc[9:2]]; m_dpc = m_pc; m_pc = m_pc + 32'd4;
      end
      e.pc = m_pc; e.insn = m_insn; e.dpc = m_dpc;
      sb.push_back(e);
      @(negedge clk);
    end
    check(bubbles_dut == bubbles_model, "R6 bubble count", 32'(bubbles_dut), 32'(bubbles_model));
    check(bubbles_model > 10, "R5 taken branches seen", 32'(bubbles_model), 32'd11);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule